// File: doc/BRIEF.md
# Lockable Round-Robin Victim Selector

This block picks which way of a set-associative cache gets replaced on a miss. Every set keeps its own rotation pointer. A victim request names a set. One cycle later the block returns a way, registered. The chosen way is the first way at or after that set's pointer that is not locked, searching upward and wrapping past the top way. The pointer moves only when the cache reports that a fill into that set has committed. Repeated lookups before a fill therefore keep naming the same way.

Software can pin individual ways of a set so that they are never replaced, for example to keep critical data resident or to use the way as local scratch memory. It does this through a configuration port. Each set may hold at most `MAX_LOCKED` pinned ways, so some ways always stay replaceable. A lock request beyond that limit is refused and reported with a one-cycle error pulse.

A small build (`NUM_WAYS = 2`, `LOCK_EN = 0`) keeps the plain rotation and drops all lock state. The block holds no tag or data storage. `NUM_SETS` and `NUM_WAYS` must be powers of two.

Top module: `way_victim_sel`

## Requirements
- R1: After reset no way of any set is locked, every set's pointer is at way 0, and `victimValid` and `lockErr` are low.
- R2: `victimValid` is high in exactly the cycle after a cycle with `reqValid` high, and low otherwise. `victimWay` is valid in that cycle.
- R3: Each set has its own pointer. A fill commit for one set does not change the victim returned for any other set.
- R4: When `fillCommit` is high, the pointer of `fillSet` moves to the way just above the victim that set would currently return, wrapping from way `NUM_WAYS-1` to way 0.
- R5: Without a fill commit, repeated requests for a set return the same way.
- R6: The returned way is the first unlocked way, searching upward from the set's pointer and wrapping past the top way. Locked ways are never returned.
- R7: With `cfgValid` high, `cfgLock`=1 locks way `cfgWay` of set `cfgSet` and `cfgLock`=0 unlocks it. The change affects requests from the next cycle on.
- R8: A lock request for an unlocked way in a set that already has `MAX_LOCKED` locked ways is refused. The set's lock state stays unchanged, and `lockErr` is high for exactly the one following cycle.
- R9: Locking a way that is already locked, and any unlock, never raises `lockErr`.
- R10: With `LOCK_EN`=0, configuration requests have no effect: no way is ever skipped and `lockErr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Victim request strobe |
| reqSet | input | $clog2(NUM_SETS) | Set index of the request |
| fillCommit | input | 1 | A fill into `fillSet` has committed |
| fillSet | input | $clog2(NUM_SETS) | Set index of the committed fill |
| cfgValid | input | 1 | Lock configuration strobe |
| cfgLock | input | 1 | 1 = lock the way, 0 = unlock it |
| cfgSet | input | $clog2(NUM_SETS) | Set index of the configuration request |
| cfgWay | input | $clog2(NUM_WAYS) | Way index of the configuration request |
| victimValid | output | 1 | `victimWay` is valid |
| victimWay | output | $clog2(NUM_WAYS) | Chosen replacement way |
| lockErr | output | 1 | The previous lock request was refused |

## Verification
The selector is driven with fresh sets, with repeated requests that have no fill between them, and with long fill runs that wrap the pointer. These separate a pointer that holds still from one that moves, and a set-local pointer from a shared one. Lock patterns at both the bottom and the top of the way range check that the search skips pinned ways upward and wraps correctly. Filling a set up to the lock limit, then re-locking an already locked way, then unlocking and locking again, separates a refused request from one that is accepted or that changes nothing. A second two-way build without locking shows that configuration requests leave its rotation untouched.

// File: rtl/way_victim_sel_pkg.sv
package way_victim_sel_pkg;
  typedef struct packed {
    logic doReq;
    logic doFill;
    logic doLock;
    logic doUnlock;
    logic rejectLock;
  } vselStrobes_t;
endpackage

// File: rtl/way_victim_sel_ctrl.sv
module way_victim_sel_ctrl
  import way_victim_sel_pkg::*;
#(
  parameter int LOCK_EN    = 1,
  parameter int MAX_LOCKED = 28,
  parameter int CNTW       = 6
) (
  input  logic            reqValid,
  input  logic            fillCommit,
  input  logic            cfgValid,
  input  logic            cfgLock,
  input  logic [CNTW-1:0] rowLockCount,
  input  logic            rowWayLocked,
  output vselStrobes_t    strobes
);
  localparam logic [CNTW-1:0] LIMIT = CNTW'(MAX_LOCKED);

  always_comb begin
    strobes        = '0;
    strobes.doReq  = reqValid;
    strobes.doFill = fillCommit;
    if (LOCK_EN != 0 && cfgValid) begin
      if (cfgLock) begin
        // an already locked way needs no change and raises no error
        if (!rowWayLocked) begin
          if (rowLockCount >= LIMIT) strobes.rejectLock = 1'b1;
          else                       strobes.doLock     = 1'b1;
        end
      end else begin
        strobes.doUnlock = 1'b1;
      end
    end
  end
endmodule

// File: rtl/way_victim_sel_dp.sv
module way_victim_sel_dp
  import way_victim_sel_pkg::*;
#(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int LOCK_EN  = 1,
  localparam int SETW = $clog2(NUM_SETS),
  localparam int WAYW = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int CNTW = $clog2(NUM_WAYS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  vselStrobes_t    strobes,
  input  logic [SETW-1:0] reqSet,
  input  logic [SETW-1:0] fillSet,
  input  logic [SETW-1:0] cfgSet,
  input  logic [WAYW-1:0] cfgWay,
  output logic [CNTW-1:0] rowLockCount,
  output logic            rowWayLocked,
  output logic            victimValid,
  output logic [WAYW-1:0] victimWay,
  output logic            lockErr
);
  logic [NUM_WAYS-1:0] lockRows [NUM_SETS];
  logic [WAYW-1:0]     ptrs     [NUM_SETS];
  logic [WAYW-1:0]     reqPick;
  logic [WAYW-1:0]     fillPick;

  // first unlocked way at or above start, wrapping (power-of-two ways)
  function automatic logic [WAYW-1:0] pickWay(input logic [NUM_WAYS-1:0] row,
                                              input logic [WAYW-1:0] start);
    logic [WAYW-1:0] idx;
    logic            found;
    pickWay = start;
    found   = 1'b0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      idx = start + WAYW'(k);
      if (!found && !row[idx]) begin
        pickWay = idx;
        found   = 1'b1;
      end
    end
  endfunction

  generate
    if (LOCK_EN != 0) begin : g_lock
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_SETS; s++) lockRows[s] <= '0;
        end else if (strobes.doLock) begin
          lockRows[cfgSet][cfgWay] <= 1'b1;
        end else if (strobes.doUnlock) begin
          lockRows[cfgSet][cfgWay] <= 1'b0;
        end
      end
    end else begin : g_nolock
      for (genvar s = 0; s < NUM_SETS; s++) begin : g_row
        assign lockRows[s] = '0;
      end
    end
  endgenerate

  assign rowLockCount = CNTW'($countones(lockRows[cfgSet]));
  assign rowWayLocked = lockRows[cfgSet][cfgWay];
  assign reqPick      = pickWay(lockRows[reqSet], ptrs[reqSet]);
  assign fillPick     = pickWay(lockRows[fillSet], ptrs[fillSet]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ptrs[s] <= '0;
    end else if (strobes.doFill) begin
      ptrs[fillSet] <= fillPick + WAYW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
      lockErr     <= 1'b0;
    end else begin
      victimValid <= strobes.doReq;
      lockErr     <= strobes.rejectLock;
      if (strobes.doReq) victimWay <= reqPick;
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import way_victim_sel_pkg::*;
#(
  parameter int NUM_SETS   = 32,
  parameter int NUM_WAYS   = 32,
  parameter int LOCK_EN    = 1,
  parameter int MAX_LOCKED = 28,
  localparam int SETW = $clog2(NUM_SETS),
  localparam int WAYW = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int CNTW = $clog2(NUM_WAYS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [SETW-1:0] reqSet,
  input  logic            fillCommit,
  input  logic [SETW-1:0] fillSet,
  input  logic            cfgValid,
  input  logic            cfgLock,
  input  logic [SETW-1:0] cfgSet,
  input  logic [WAYW-1:0] cfgWay,
  output logic            victimValid,
  output logic [WAYW-1:0] victimWay,
  output logic            lockErr
);
  vselStrobes_t    strobes;
  logic [CNTW-1:0] rowLockCount;
  logic            rowWayLocked;

  way_victim_sel_ctrl #(
    .LOCK_EN(LOCK_EN), .MAX_LOCKED(MAX_LOCKED), .CNTW(CNTW)
  ) u_ctrl (
    .reqValid(reqValid), .fillCommit(fillCommit), .cfgValid(cfgValid),
    .cfgLock(cfgLock), .rowLockCount(rowLockCount),
    .rowWayLocked(rowWayLocked), .strobes(strobes)
  );

  way_victim_sel_dp #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .LOCK_EN(LOCK_EN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqSet(reqSet),
    .fillSet(fillSet), .cfgSet(cfgSet), .cfgWay(cfgWay),
    .rowLockCount(rowLockCount), .rowWayLocked(rowWayLocked),
    .victimValid(victimValid), .victimWay(victimWay), .lockErr(lockErr)
  );
endmodule

// File: rtl/way_victim_sel_checker.sv
module way_victim_sel_checker (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic cfgValid,
  input logic cfgLock,
  input logic victimValid,
  input logic lockErr
);
  assert_victim_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> victimValid);
  assert_no_spurious_victim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !victimValid);
  assert_err_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lockErr |-> $past(cfgValid && cfgLock));
  assert_unlock_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgValid && !cfgLock) |=> !lockErr);
  assert_idle_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgValid |=> !lockErr);
endmodule

bind way_victim_sel way_victim_sel_checker u_checker (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .cfgValid(cfgValid),
  .cfgLock(cfgLock), .victimValid(victimValid), .lockErr(lockErr)
);

// File: tb/way_victim_sel_bench.sv
module way_victim_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 32;
  localparam int WAYS = 32;
  localparam int LIMIT = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, fillCommit = 1'b0, cfgValid = 1'b0, cfgLock = 1'b0;
  logic [4:0] reqSet = '0, fillSet = '0, cfgSet = '0, cfgWay = '0;
  logic victimValid, lockErr;
  logic [4:0] victimWay;

  logic mReq = 1'b0, mFill = 1'b0, mCfg = 1'b0, mLock = 1'b0;
  logic [4:0] mReqSet = '0, mFillSet = '0, mCfgSet = '0;
  logic [0:0] mCfgWay = '0;
  logic mVictimValid, mLockErr;
  logic [0:0] mVictimWay;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int expQ[$];
  string tagQ[$];

  bit [WAYS-1:0] modelLock [SETS];
  int modelPtr [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  way_victim_sel u_way_victim_sel (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqSet(reqSet),
    .fillCommit(fillCommit), .fillSet(fillSet), .cfgValid(cfgValid),
    .cfgLock(cfgLock), .cfgSet(cfgSet), .cfgWay(cfgWay),
    .victimValid(victimValid), .victimWay(victimWay), .lockErr(lockErr)
  );

  way_victim_sel #(.NUM_SETS(32), .NUM_WAYS(2), .LOCK_EN(0), .MAX_LOCKED(0))
  u_way_victim_sel_mini (
    .clk(clk), .rst_n(rst_n), .reqValid(mReq), .reqSet(mReqSet),
    .fillCommit(mFill), .fillSet(mFillSet), .cfgValid(mCfg),
    .cfgLock(mLock), .cfgSet(mCfgSet), .cfgWay(mCfgWay),
    .victimValid(mVictimValid), .victimWay(mVictimWay), .lockErr(mLockErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPick(input int s);
    for (int k = 0; k < WAYS; k++) begin
      int idx = (modelPtr[s] + k) % WAYS;
      if (!modelLock[s][idx]) return idx;
    end
    return -1;
  endfunction

  task automatic doReq(input int s, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqSet = 5'(s);
    expQ.push_back(expPick(s));
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doFill(input int s);
    @(negedge clk);
    fillCommit = 1'b1; fillSet = 5'(s);
    modelPtr[s] = (expPick(s) + 1) % WAYS;
    @(negedge clk);
    fillCommit = 1'b0;
  endtask

  task automatic doCfg(input int s, input int w, input bit lk, input string tag);
    bit expErr;
    expErr = lk && !modelLock[s][w] && ($countones(modelLock[s]) >= LIMIT);
    @(negedge clk);
    cfgValid = 1'b1; cfgLock = lk; cfgSet = 5'(s); cfgWay = 5'(w);
    @(negedge clk);
    cfgValid = 1'b0;
    check(lockErr == expErr, tag, int'(lockErr), int'(expErr));
    if (!expErr) modelLock[s][w] = lk;
    if (expErr) begin
      @(negedge clk);
      check(lockErr == 1'b0, {tag, " pulse length"}, int'(lockErr), 0);
    end
  endtask

  // monitor: pops expected victims as the design produces them
  always @(negedge clk) begin
    if (rst_n && victimValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected victimValid", 1, 0);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(victimWay) == e, t, int'(victimWay), e);
      end
    end
  end

  task automatic miniReq(input int exp, input string tag);
    @(negedge clk);
    mReq = 1'b1; mReqSet = 5'd9;
    @(negedge clk);
    mReq = 1'b0;
    check(mVictimValid == 1'b1, {tag, " valid"}, int'(mVictimValid), 1);
    check(int'(mVictimWay) == exp, tag, int'(mVictimWay), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      modelLock[s] = '0;
      modelPtr[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(victimValid == 1'b0, "R1 victimValid in reset", int'(victimValid), 0);
    check(lockErr == 1'b0, "R1 lockErr in reset", int'(lockErr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(victimValid == 1'b0, "R1 victimValid after reset", int'(victimValid), 0);

    doReq(0, "R1 set 0 starts at way 0");
    doReq(31, "R1 set 31 starts at way 0");
    doReq(0, "R5 repeat request same way");

    for (int i = 0; i < 3; i++) begin
      doFill(3);
      doReq(3, "R4 fill advances pointer");
    end
    doReq(4, "R3 neighbour set unchanged");

    for (int i = 0; i < 31; i++) doFill(5);
    doReq(5, "R4 pointer at top way");
    doFill(5);
    doReq(5, "R4 pointer wraps to way 0");

    doCfg(6, 0, 1'b1, "R7 lock way 0");
    doCfg(6, 1, 1'b1, "R7 lock way 1");
    doCfg(6, 2, 1'b1, "R7 lock way 2");
    doReq(6, "R6 skips locked ways 0..2");
    doCfg(6, 1, 1'b0, "R9 unlock way 1");
    doReq(6, "R7 unlocked way 1 usable");

    for (int i = 0; i < 30; i++) doFill(7);
    doCfg(7, 30, 1'b1, "R7 lock way 30");
    doCfg(7, 31, 1'b1, "R7 lock way 31");
    doReq(7, "R6 search wraps past top");
    doFill(7);
    doReq(7, "R4 fill after wrap");

    for (int w = 0; w < LIMIT; w++) doCfg(8, w, 1'b1, "R7 fill set 8 to limit");
    doCfg(8, 28, 1'b1, "R8 lock beyond limit refused");
    doReq(8, "R8 refused way stays replaceable");
    for (int i = 0; i < 4; i++) begin
      doFill(8);
      doReq(8, "R6 rotation over unlocked ways only");
    end
    doCfg(8, 5, 1'b1, "R9 relock locked way no error");
    doCfg(8, 3, 1'b0, "R9 unlock at limit");
    doCfg(8, 28, 1'b1, "R8 lock accepted below limit");
    doReq(8, "R6 after relock");
    doCfg(8, 29, 1'b1, "R8 limit again refused");
    doReq(0, "R3 set 0 untouched");

    @(negedge clk);
    mCfg = 1'b1; mLock = 1'b1; mCfgSet = 5'd9; mCfgWay = 1'b0;
    @(negedge clk);
    mCfg = 1'b0;
    check(mLockErr == 1'b0, "R10 no lockErr without locking", int'(mLockErr), 0);
    miniReq(0, "R10 lock ignored way 0 chosen");
    @(negedge clk); mFill = 1'b1; mFillSet = 5'd9;
    @(negedge clk); mFill = 1'b0;
    miniReq(1, "R4 two-way rotation");
    @(negedge clk); mFill = 1'b1;
    @(negedge clk); mFill = 1'b0;
    miniReq(0, "R4 two-way wrap");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all requests answered", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule